// File: doc/BRIEF.md
# VGA Legacy Address Forwarding Filter

This block sits in a bridge between an upstream serial link and a downstream legacy parallel bus. For each request it is handed, it decides whether the access is a legacy VGA access that the bridge should pass across. It also decides whether that pass is allowed under the current enables. A request carries an address, a memory-or-I/O flag and a direction flag. The block answers with a registered forward/ignore bit and a two-bit reason code. Addresses that are not VGA resources get reason "no hit", so that the bridge's general window logic can handle them.

Two VGA resources are recognised. The first is the frame buffer memory window from 0x000A_0000 to 0x000B_FFFF inclusive. The second is the set of display I/O ports. A port matches on address bits [9:0] only: bits [15:10] may take any value, and bits [31:16] must be zero. As a result, each 1 KB alias inside the first 64 KB of I/O space matches. Three enable inputs gate the decision: VGA enable, memory range forward enable and bus master enable. These enables are captured in a register, and a request uses the captured copy.

Control is a two-state machine. `S_IDLE` accepts a request: `req_ready` is high, and the transition IDLE→HOLD fires on `req_valid`. `S_HOLD` presents the decision: `dec_valid` is high and `req_ready` is low. The transition HOLD→IDLE fires on `dec_ready`. Reset enters `S_IDLE`.

Top module: `vga_fwd_filter`

## Requirements
- R1: After reset `dec_valid` is 0, `req_ready` is 1, and the captured enables are all 0, so a request accepted on the first clock edge after reset is decided as if every enable were off.
- R2: A memory request (`req_is_io`=0) with address in 0x000A_0000..0x000B_FFFF inclusive is a frame buffer hit. The addresses 0x0009_FFFF and 0x000C_0000 are not hits.
- R3: An I/O request (`req_is_io`=1) is a port hit when bits [9:0] lie in 0x3B0..0x3BB or 0x3C0..0x3DF and bits [31:16] are zero. Bits [15:10] take any value.
- R4: I/O addresses with bits [9:0] in 0x3BC..0x3BF, or with any bit of [31:16] set, are not port hits and give reason 00.
- R5: An upstream request (`req_upstream`=1) that is a port hit is never forwarded. It gives `dec_forward`=0 and reason 11.
- R6: An upstream frame buffer hit is forwarded (reason 01) only when both memory range forward enable and bus master enable are 1. Otherwise it gives reason 10.
- R7: A downstream request (`req_upstream`=0) that hits the frame buffer or a port is forwarded (reason 01) when VGA enable is 1. Otherwise it is blocked, with reason 10 for the frame buffer and 11 for a port.
- R8: A request that hits neither resource gives `dec_forward`=0 and reason 00. This includes an I/O request at a frame buffer address and a memory request at a port address.
- R9: A request accepted on an edge (`req_valid` and `req_ready` high) is decided at that edge, so `dec_valid` is 1 in the following cycle. While `dec_valid` is 1, `req_ready` is 0, and `dec_forward`/`dec_reason` hold steady until `dec_ready` is 1.
- R10: An enable input change is captured on a clock edge. A request accepted on that same edge uses the enables captured on the previous edge.
- R11: `dec_forward` is 1 exactly when `dec_reason` is 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_vga_en | input | 1 | VGA resource enable |
| cfg_mem_fwd_en | input | 1 | Memory range forward enable |
| cfg_master_en | input | 1 | Bus master enable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_addr | input | 32 | Request address |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_upstream | input | 1 | 1 = legacy bus toward serial link, 0 = the reverse |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Decision consumed when high with `dec_valid` |
| dec_forward | output | 1 | 1 = forward across the bridge |
| dec_reason | output | 2 | 00 no hit, 01 forwarded, 10 frame buffer blocked, 11 port blocked |

## Verification
Two things can land on the same clock edge: an enable update being captured, and a request being accepted. The bench changes an enable input in the same cycle in which it presents a request to an idle block. It then expects a decision based on the enables from before that edge. Meanwhile the output side is stalled with an irregular `dec_ready` pattern. This shows that the held decision does not change and that no new request is taken while a decision is still pending.

// File: rtl/vga_filt_pkg.sv
package vga_filt_pkg;

    localparam int ADDR_W        = 32;
    localparam int IO_ALIAS_BITS = 10;
    localparam int IO_SPACE_BITS = 16;
    localparam int N_PORT_RANGES = 2;

    localparam logic [ADDR_W-1:0] FB_FIRST = 32'h000A_0000;
    localparam logic [ADDR_W-1:0] FB_LAST  = 32'h000B_FFFF;

    localparam logic [ADDR_W-1:0] PORT_LO [N_PORT_RANGES] = '{32'h0000_03B0, 32'h0000_03C0};
    localparam logic [ADDR_W-1:0] PORT_HI [N_PORT_RANGES] = '{32'h0000_03BB, 32'h0000_03DF};

    typedef enum logic [1:0] {
        RSN_NONE   = 2'b00,
        RSN_FWD    = 2'b01,
        RSN_FB_BLK = 2'b10,
        RSN_IO_BLK = 2'b11
    } reason_e;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_HOLD = 1'b1
    } fsm_e;

    typedef struct packed {
        logic vga_en;
        logic mem_fwd_en;
        logic master_en;
    } vga_cfg_t;

endpackage

// File: rtl/vga_cfg_stage.sv
module vga_cfg_stage
    import vga_filt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  vga_cfg_t cfg_in,
    output vga_cfg_t cfg_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/vga_addr_decode.sv
module vga_addr_decode
    import vga_filt_pkg::*;
#(
    parameter int AW         = ADDR_W,
    parameter int ALIAS_BITS = IO_ALIAS_BITS,
    parameter int SPACE_BITS = IO_SPACE_BITS,
    parameter int N_RANGES   = N_PORT_RANGES
) (
    input  logic [AW-1:0] addr,
    input  logic          is_io,
    output logic          fb_hit,
    output logic          port_hit
);

    // Keep the low alias field and everything above the I/O space; the
    // bits between them repeat the ports every 1 KB and are cleared.
    localparam logic [AW-1:0] SPACE_MASK = AW'((64'd1 << SPACE_BITS) - 64'd1);
    localparam logic [AW-1:0] ALIAS_MASK = AW'((64'd1 << ALIAS_BITS) - 64'd1);
    localparam logic [AW-1:0] KEEP_MASK  = ~(SPACE_MASK & ~ALIAS_MASK);

    logic [AW-1:0]       io_view;
    logic [N_RANGES-1:0] range_hit;

    assign io_view = addr & KEEP_MASK;

    // A nonzero upper field pushes io_view above every port range.
    for (genvar g = 0; g < N_RANGES; g++) begin : g_port_range
        assign range_hit[g] = (io_view >= PORT_LO[g]) && (io_view <= PORT_HI[g]);
    end

    always_comb begin
        fb_hit   = !is_io && (addr >= FB_FIRST) && (addr <= FB_LAST);
        port_hit = is_io && (|range_hit);
    end

endmodule

// File: rtl/vga_fwd_policy.sv
module vga_fwd_policy
    import vga_filt_pkg::*;
(
    input  logic     fb_hit,
    input  logic     port_hit,
    input  logic     upstream,
    input  vga_cfg_t cfg,
    output logic     forward,
    output reason_e  reason
);

    always_comb begin
        reason = RSN_NONE;
        if (fb_hit) begin
            if (upstream) begin
                reason = (cfg.mem_fwd_en && cfg.master_en) ? RSN_FWD : RSN_FB_BLK;
            end else begin
                reason = cfg.vga_en ? RSN_FWD : RSN_FB_BLK;
            end
        end else if (port_hit) begin
            if (upstream) begin
                reason = RSN_IO_BLK;
            end else begin
                reason = cfg.vga_en ? RSN_FWD : RSN_IO_BLK;
            end
        end
        forward = (reason == RSN_FWD);
    end

endmodule

// File: rtl/vga_fwd_filter.sv
module vga_fwd_filter
    import vga_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_vga_en,
    input  logic              cfg_mem_fwd_en,
    input  logic              cfg_master_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_io,
    input  logic              req_upstream,
    output logic              dec_valid,
    input  logic              dec_ready,
    output logic              dec_forward,
    output logic [1:0]        dec_reason
);

    fsm_e     state, state_nx;
    vga_cfg_t cfg_in, cfg_q;
    logic     fb_hit, port_hit, pol_forward;
    reason_e  pol_reason;
    logic     take;

    assign cfg_in = '{vga_en: cfg_vga_en, mem_fwd_en: cfg_mem_fwd_en, master_en: cfg_master_en};

    vga_cfg_stage u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    vga_addr_decode u_dec (
        .addr     (req_addr),
        .is_io    (req_is_io),
        .fb_hit   (fb_hit),
        .port_hit (port_hit)
    );

    vga_fwd_policy u_pol (
        .fb_hit   (fb_hit),
        .port_hit (port_hit),
        .upstream (req_upstream),
        .cfg      (cfg_q),
        .forward  (pol_forward),
        .reason   (pol_reason)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (req_valid) state_nx = S_HOLD;
            S_HOLD: if (dec_ready) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    assign req_ready = (state == S_IDLE);
    assign dec_valid = (state == S_HOLD);
    assign take      = req_valid && req_ready;

    // Decision register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_forward <= 1'b0;
            dec_reason  <= RSN_NONE;
        end else if (take) begin
            dec_forward <= pol_forward;
            dec_reason  <= pol_reason;
        end
    end

    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> dec_valid);

    a_r9_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_forward) && $stable(dec_reason)));

    a_r5_port_up_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (take && port_hit && req_upstream) |=> (!dec_forward && dec_reason == RSN_IO_BLK));

    a_r4_upper_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_is_io && (req_addr[ADDR_W-1:IO_SPACE_BITS] != '0)) |=> (dec_reason == RSN_NONE));

    a_r11_forward_code: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_forward == (dec_reason == RSN_FWD)));

    a_r8_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !fb_hit && !port_hit) |=> (!dec_forward && dec_reason == RSN_NONE));

endmodule

// File: tb/test_vga_fwd_filter.sv
module test_vga_fwd_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_vga_en = 1'b0, cfg_mem_fwd_en = 1'b0, cfg_master_en = 1'b0;
    logic        req_valid = 1'b0, req_is_io = 1'b0, req_upstream = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, dec_valid, dec_forward;
    logic        dec_ready = 1'b0;
    logic [1:0]  dec_reason;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        logic       fwd;
        logic [1:0] rsn;
        string      tag;
    } exp_t;
    exp_t sb[$];

    // Captured enables as the requirement defines them (R10).
    logic eff_vga = 1'b0, eff_mem = 1'b0, eff_mst = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    vga_fwd_filter i_vga_fwd_filter (
        .clk(clk), .rst_n(rst_n),
        .cfg_vga_en(cfg_vga_en), .cfg_mem_fwd_en(cfg_mem_fwd_en), .cfg_master_en(cfg_master_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_is_io(req_is_io), .req_upstream(req_upstream),
        .dec_valid(dec_valid), .dec_ready(dec_ready),
        .dec_forward(dec_forward), .dec_reason(dec_reason)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eff_vga <= 1'b0; eff_mem <= 1'b0; eff_mst <= 1'b0;
        end else begin
            eff_vga <= cfg_vga_en; eff_mem <= cfg_mem_fwd_en; eff_mst <= cfg_master_en;
        end
        cycles++;
    end

    function automatic logic [1:0] model(input logic [31:0] a, input logic io, input logic up,
                                         input logic v, input logic m, input logic b);
        logic fb, ph;
        logic [9:0] lo;
        lo = a[9:0];
        fb = !io && a >= 32'h000A_0000 && a <= 32'h000B_FFFF;
        ph = io && a[31:16] == 16'h0 &&
             ((lo >= 10'h3B0 && lo <= 10'h3BB) || (lo >= 10'h3C0 && lo <= 10'h3DF));
        if (fb)      return up ? ((m && b) ? 2'b01 : 2'b10) : (v ? 2'b01 : 2'b10);
        else if (ph) return up ? 2'b11 : (v ? 2'b01 : 2'b11);
        else         return 2'b00;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Driver: presents a request at a falling edge and pushes the expected decision.
    task automatic send(input logic [31:0] a, input logic io, input logic up, input string tag);
        exp_t e;
        @(negedge clk);
        req_addr = a; req_is_io = io; req_upstream = up; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        e.rsn = model(a, io, up, eff_vga, eff_mem, eff_mst);
        e.fwd = (e.rsn == 2'b01);
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        check(dec_valid === 1'b1, "R9", "dec_valid one cycle after accept", 32'(dec_valid), 1);
        check(req_ready === 1'b0, "R9", "req_ready low while held", 32'(req_ready), 0);
    endtask

    task automatic set_cfg(input logic v, input logic m, input logic b);
        @(negedge clk);
        cfg_vga_en = v; cfg_mem_fwd_en = m; cfg_master_en = b;
        @(negedge clk);
    endtask

    task automatic drain();
        while (sb.size() != 0 || dec_valid) @(negedge clk);
    endtask

    // Monitor: decides dec_ready and pops/compares on each handshake.
    initial begin : monitor
        int          n = 0;
        logic        held = 1'b0;
        logic        h_fwd;
        logic [1:0]  h_rsn;
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            n++;
            if (dec_valid) begin
                if (held) begin
                    check(dec_forward === h_fwd && dec_reason === h_rsn, "R9",
                          "decision steady under stall", {dec_forward, dec_reason}, {h_fwd, h_rsn});
                end
                dec_ready = ((n % 5) != 1) && ((n % 7) != 3);
                if (dec_ready) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R9", "unexpected decision", {dec_forward, dec_reason}, 0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(dec_reason === e.rsn, e.tag, "dec_reason", 32'(dec_reason), 32'(e.rsn));
                        check(dec_forward === e.fwd, "R11", "dec_forward", 32'(dec_forward), 32'(e.fwd));
                    end
                    held = 1'b0;
                end else begin
                    held = 1'b1; h_fwd = dec_forward; h_rsn = dec_reason;
                end
            end else begin
                dec_ready = 1'b0;
                held = 1'b0;
            end
        end
    end

    initial begin : watchdog
        wait (cycles > 50000);
        errors++;
        $display("FAIL R9 watchdog expired actual=%0d expected=<50000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stimulus
        // R1: enables driven high during reset, still read as off right after it.
        cfg_vga_en = 1'b1; cfg_mem_fwd_en = 1'b1; cfg_master_en = 1'b1;
        repeat (3) @(negedge clk);
        check(dec_valid === 1'b0, "R1", "dec_valid in reset", 32'(dec_valid), 0);
        check(req_ready === 1'b1, "R1", "req_ready in reset", 32'(req_ready), 1);
        rst_n = 1'b1;
        req_addr = 32'h000A_0000; req_is_io = 1'b0; req_upstream = 1'b0; req_valid = 1'b1;
        begin
            exp_t e;
            e.rsn = 2'b10; e.fwd = 1'b0; e.tag = "R1";
            sb.push_back(e);
        end
        @(negedge clk);
        req_valid = 1'b0;
        drain();

        // R2/R7: downstream frame buffer edges, enabled.
        send(32'h000A_0000, 1'b0, 1'b0, "R2");
        send(32'h000B_FFFF, 1'b0, 1'b0, "R2");
        send(32'h0009_FFFF, 1'b0, 1'b0, "R2");
        send(32'h000C_0000, 1'b0, 1'b0, "R2");
        // R3: ports and aliases.
        send(32'h0000_03B0, 1'b1, 1'b0, "R3");
        send(32'h0000_03BB, 1'b1, 1'b0, "R3");
        send(32'h0000_03C0, 1'b1, 1'b0, "R3");
        send(32'h0000_03DF, 1'b1, 1'b0, "R3");
        send(32'h0000_07BB, 1'b1, 1'b0, "R3");
        send(32'h0000_FFC0, 1'b1, 1'b0, "R3");
        // R4: gaps and upper field.
        send(32'h0000_03BC, 1'b1, 1'b0, "R4");
        send(32'h0000_03BF, 1'b1, 1'b0, "R4");
        send(32'h0001_03B0, 1'b1, 1'b0, "R4");
        send(32'h8000_03C5, 1'b1, 1'b0, "R4");
        send(32'h0000_03AF, 1'b1, 1'b0, "R4");
        send(32'h0000_03E0, 1'b1, 1'b0, "R4");
        // R5: upstream ports never forwarded.
        send(32'h0000_03C5, 1'b1, 1'b1, "R5");
        send(32'h0000_2FB4, 1'b1, 1'b1, "R5");
        // R6: upstream frame buffer with all enable pairs.
        send(32'h000B_0000, 1'b0, 1'b1, "R6");
        set_cfg(1'b1, 1'b0, 1'b1);
        send(32'h000B_0000, 1'b0, 1'b1, "R6");
        set_cfg(1'b1, 1'b1, 1'b0);
        send(32'h000A_8000, 1'b0, 1'b1, "R6");
        set_cfg(1'b0, 1'b0, 1'b0);
        send(32'h000A_8000, 1'b0, 1'b1, "R6");
        set_cfg(1'b0, 1'b1, 1'b1);
        send(32'h000A_8000, 1'b0, 1'b1, "R6");
        // R7: downstream with VGA enable off.
        send(32'h000A_0010, 1'b0, 1'b0, "R7");
        send(32'h0000_03D4, 1'b1, 1'b0, "R7");
        // R8: wrong space.
        set_cfg(1'b1, 1'b1, 1'b1);
        send(32'h000A_0000, 1'b1, 1'b0, "R8");
        send(32'h0000_03B0, 1'b0, 1'b0, "R8");
        send(32'h1234_5678, 1'b0, 1'b1, "R8");
        // R10: enable change on the acceptance edge; old enables apply.
        drain();
        @(negedge clk);
        cfg_vga_en = 1'b0;
        req_addr = 32'h0000_03C0; req_is_io = 1'b1; req_upstream = 1'b0; req_valid = 1'b1;
        begin
            exp_t e;
            e.rsn = 2'b01; e.fwd = 1'b1; e.tag = "R10";
            sb.push_back(e);
        end
        @(negedge clk);
        req_valid = 1'b0;
        drain();
        send(32'h0000_03C0, 1'b1, 1'b0, "R10");
        drain();
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule